// File: doc/BRIEF.md
# Multichannel Receive Word Collector with Sequenced Shared Read

This block collects audio words arriving from several serial links. Each link carries a left and a right channel. The block hands the words to a host through a single shared read port. Upstream deserializers raise a one-cycle strobe with a word for a channel. The block records the word and raises that channel's ready flag. When a word arrives for a channel that still holds an unread word, the block raises that channel's overrun flag instead. The host reads a status strobe to clear the overrun flags.

With the queue switched off, each channel keeps one holding register. Successive host reads step a sequence pointer through the enabled channels in one of three orders:
- all left channels, then all right channels;
- link by link, left then right;
- ascending slot order for time-division framing.

With the queue switched on, words go into a first-in first-out memory in arrival order. When that memory is full, a small spill bank holds the extra words. A word is dropped and flagged as an overrun only after both are full.

Channel index c is 2*link + side, where side 0 is left and side 1 is right. The word for channel c sits at bits [c*DATA_W +: DATA_W] of `in_data`.

Top module: `rx_gather_seq`

## Requirements
- R1: After synchronous reset, `rdy_flags` and `ovr_flags` are all zero and `rd_vld` is low.
- R2: A strobe on `in_vld[c]` is accepted only while `en` is high and `chan_en[c]` is set. An accepted strobe sets `rdy_flags[c]`. A strobe on a disabled channel, or while `en` is low, sets no flag.
- R3: With `tdm_mode`=0, `pair_order`=0 and the queue off, successive reads return the enabled left channels (c = 0, 2, 4, …), then the enabled right channels (c = 1, 3, 5, …), and then wrap.
- R4: With `tdm_mode`=0, `pair_order`=1 and the queue off, successive reads return link 0 left, link 0 right, link 1 left, and so on, which is ascending c.
- R5: With `tdm_mode`=1, reads return the enabled slots in ascending c, whatever the value of `pair_order`.
- R6: The sequence skips channels whose `chan_en` bit is clear and wraps after the last enabled position.
- R7: The sequence pointer returns to the first enabled position when `en`, `tdm_mode`, `pair_order` or `chan_en` changes.
- R8: With the queue off, a word that arrives for a channel whose ready flag is set raises that channel's overrun flag. The word is dropped, and the held word is kept.
- R9: A `stat_rd` pulse clears all overrun flags. An overrun in the same cycle still sets its flag.
- R10: With `fifo_en`=1, FIFO_DEPTH + HOLD_SLOTS words are accepted with no reads and no overrun. The next word raises the overrun flag of its channel. Reads then return the accepted words in arrival order.
- R11: With `fifo_en`=1, a read of an empty queue returns zero data. A read that returns a word for channel c clears `rdy_flags[c]` within two cycles.
- R12: A read is answered in the cycle after `rd_en`: `rd_vld` is high, `rd_chan` gives the channel, and `rd_data` holds the word right-justified with zero upper bits.
- R13: At most one bit of `in_vld` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| tdm_mode | input | 1 | 1: slot order for time-division framing |
| pair_order | input | 1 | Stereo order: 0 all-left-then-all-right, 1 link by link |
| fifo_en | input | 1 | 1: queue mode, 0: per-channel holding |
| chan_en | input | 2*NUM_LINKS | Channel enable mask, indexed by c |
| in_vld | input | 2*NUM_LINKS | New-word strobe per channel |
| in_data | input | 2*NUM_LINKS*DATA_W | Word per channel, packed by c |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | BUS_W | Read word, right-justified |
| rd_chan | output | clog2(2*NUM_LINKS) | Channel of the read word |
| rd_vld | output | 1 | Read answer valid |
| stat_rd | input | 1 | Status read strobe, clears overrun flags |
| rdy_flags | output | 2*NUM_LINKS | Per-channel ready flags |
| ovr_flags | output | 2*NUM_LINKS | Per-channel overrun flags |

## Verification
A wrong sequence pointer shows up on the first read after the fault. `rd_chan` names an unexpected channel, and `rd_data` carries that channel's word, so each read in the directed orders is compared on both fields. A lost or reordered queue entry shows up one read later as data out of arrival order. A wrong acceptance decision shows up on `ovr_flags` in the cycle right after the overflowing strobe. Wrong flag handling shows up on the flag outputs one or two cycles after the strobe or read that should have changed them.

// File: rtl/rxs_pkg.sv
`timescale 1ns/1ps
package rxs_pkg;
  // Map a position in the read sequence to a channel index (c = 2*link + side).
  function automatic int pos2chan(input int k, input int nl, input logic tdm, input logic pair);
    if (tdm || pair) return k;
    if (k < nl) return 2 * k;
    return 2 * (k - nl) + 1;
  endfunction
endpackage

// File: rtl/rxs_seq.sv
`timescale 1ns/1ps
module rxs_seq #(
  parameter int NUM_LINKS = 2,
  localparam int NCH = 2 * NUM_LINKS,
  localparam int PW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           tdm_mode,
  input  logic           pair_order,
  input  logic [NCH-1:0] chan_en,
  input  logic           step,
  output logic [PW-1:0]  cur_chan
);
  import rxs_pkg::*;

  logic [NCH-1:0]  en_pos;
  logic [PW-1:0]   pos_q, first_pos, next_pos;
  logic [NCH+2:0]  cfg_q, cfg_now;
  logic            restart;

  // Enable bit of each sequence position
  always_comb begin
    for (int k = 0; k < NCH; k++)
      en_pos[k] = chan_en[PW'(pos2chan(k, NUM_LINKS, tdm_mode, pair_order))];
  end

  // First enabled position and next enabled position after the current one
  always_comb begin
    first_pos = '0;
    for (int k = NCH - 1; k >= 0; k--)
      if (en_pos[k]) first_pos = PW'(k);
    next_pos = pos_q;
    for (int off = NCH - 1; off >= 1; off--)
      if (en_pos[PW'((int'(pos_q) + off) % NCH)])
        next_pos = PW'((int'(pos_q) + off) % NCH);
  end

  assign cfg_now = {en, tdm_mode, pair_order, chan_en};
  assign restart = (cfg_now != cfg_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      pos_q <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (restart)   pos_q <= first_pos;
      else if (step) pos_q <= next_pos;
    end
  end

  assign cur_chan = PW'(pos2chan(int'(pos_q), NUM_LINKS, tdm_mode, pair_order));
endmodule

// File: rtl/rxs_fifo.sv
`timescale 1ns/1ps
module rxs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wd,
  input  logic         rd,
  output logic [W-1:0] q,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = wr && !full;
  assign do_rd = rd && !empty;

  // Storage and registered read port, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wd;
    if (do_rd) q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rxs_spill.sv
`timescale 1ns/1ps
module rxs_spill #(
  parameter int W     = 8,
  parameter int SLOTS = 4,
  localparam int AW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] pd,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  slot [SLOTS];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(SLOTS));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot[rp];

  always_ff @(posedge clk) begin
    if (do_push) slot[wp] <= pd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(SLOTS - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(SLOTS - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rx_gather_seq.sv
`timescale 1ns/1ps
module rx_gather_seq #(
  parameter int NUM_LINKS  = 2,
  parameter int DATA_W     = 24,
  parameter int BUS_W      = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int HOLD_SLOTS = 4,
  localparam int NCH  = 2 * NUM_LINKS,
  localparam int CH_W = $clog2(NCH),
  localparam int EW   = CH_W + DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  tdm_mode,
  input  logic                  pair_order,
  input  logic                  fifo_en,
  input  logic [NCH-1:0]        chan_en,
  input  logic [NCH-1:0]        in_vld,
  input  logic [NCH*DATA_W-1:0] in_data,
  input  logic                  rd_en,
  output logic [BUS_W-1:0]      rd_data,
  output logic [CH_W-1:0]       rd_chan,
  output logic                  rd_vld,
  input  logic                  stat_rd,
  output logic [NCH-1:0]        rdy_flags,
  output logic [NCH-1:0]        ovr_flags
);
  // Accepted arrival, encoded
  logic [NCH-1:0]    acc;
  logic              arr;
  logic [CH_W-1:0]   arr_c;
  logic [DATA_W-1:0] arr_d;

  assign acc = in_vld & chan_en & {NCH{en}};
  assign arr = |acc;

  always_comb begin
    arr_c = '0;
    arr_d = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (acc[c]) begin
        arr_c = CH_W'(c);
        arr_d = in_data[c*DATA_W +: DATA_W];
      end
  end

  // Sequence pointer for the per-channel holding mode
  logic [CH_W-1:0] cur_chan;
  logic            seq_step;
  assign seq_step = rd_en && !fifo_en;

  rxs_seq #(.NUM_LINKS(NUM_LINKS)) u_seq (
    .clk(clk), .rst(rst), .en(en), .tdm_mode(tdm_mode),
    .pair_order(pair_order), .chan_en(chan_en),
    .step(seq_step), .cur_chan(cur_chan)
  );

  // Queue path: spill bank in front of the memory, order preserved
  logic          f_full, f_empty, s_full, s_empty;
  logic          move, direct, to_spill, drop, fifo_rd, fifo_wr;
  logic [EW-1:0] s_head, f_wd, f_q;

  assign move     = fifo_en && !s_empty && !f_full;
  assign direct   = fifo_en && arr && s_empty && !f_full;
  assign to_spill = fifo_en && arr && !direct && !s_full;
  assign drop     = fifo_en && arr && !direct && s_full;
  assign fifo_wr  = move || direct;
  assign f_wd     = move ? s_head : {arr_c, arr_d};
  assign fifo_rd  = fifo_en && rd_en && !f_empty;

  rxs_spill #(.W(EW), .SLOTS(HOLD_SLOTS)) u_spill (
    .clk(clk), .rst(rst), .push(to_spill), .pd({arr_c, arr_d}),
    .pop(move), .head(s_head), .full(s_full), .empty(s_empty)
  );

  rxs_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr(fifo_wr), .wd(f_wd), .rd(fifo_rd),
    .q(f_q), .full(f_full), .empty(f_empty)
  );

  logic [CH_W-1:0]   q_tag;
  logic [DATA_W-1:0] q_dat;
  assign q_tag = f_q[EW-1:DATA_W];
  assign q_dat = f_q[DATA_W-1:0];

  // Per-channel holding registers
  logic [DATA_W-1:0] hold [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)
        hold[g] <= '0;
      else if (!fifo_en && acc[g] && !rdy_flags[g])
        hold[g] <= in_data[g*DATA_W +: DATA_W];
    end
  end

  // Read answer registers
  logic [DATA_W-1:0] hold_out;
  logic [CH_W-1:0]   chan_out;
  logic              sel_fifo_d, pop_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_out   <= '0;
      chan_out   <= '0;
      sel_fifo_d <= 1'b0;
      pop_d      <= 1'b0;
      rd_vld     <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      pop_d  <= fifo_rd;
      if (rd_en) sel_fifo_d <= fifo_en;
      if (seq_step) begin
        hold_out <= hold[cur_chan];
        chan_out <= cur_chan;
      end
    end
  end

  always_comb begin
    if (sel_fifo_d) begin
      rd_data = pop_d ? BUS_W'(q_dat) : '0;
      rd_chan = pop_d ? q_tag : '0;
    end else begin
      rd_data = BUS_W'(hold_out);
      rd_chan = chan_out;
    end
  end

  // Ready and overrun flags; a set wins over a clear
  for (genvar g = 0; g < NCH; g++) begin : g_flag
    logic set_r, clr_r, set_o;
    assign set_r = acc[g] && (fifo_en ? (direct || to_spill) : !rdy_flags[g]);
    assign clr_r = (!fifo_en && seq_step && (cur_chan == CH_W'(g))) ||
                   (pop_d && (q_tag == CH_W'(g)));
    assign set_o = acc[g] && (fifo_en ? drop : rdy_flags[g]);

    always_ff @(posedge clk) begin
      if (rst) begin
        rdy_flags[g] <= 1'b0;
        ovr_flags[g] <= 1'b0;
      end else begin
        if (set_r)      rdy_flags[g] <= 1'b1;
        else if (clr_r) rdy_flags[g] <= 1'b0;
        if (set_o)        ovr_flags[g] <= 1'b1;
        else if (stat_rd) ovr_flags[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_gather_seq_chk.sv
`timescale 1ns/1ps
module rx_gather_seq_chk #(
  parameter int NCH    = 4,
  parameter int DATA_W = 24,
  parameter int BUS_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             fifo_en,
  input logic [NCH-1:0]   chan_en,
  input logic [NCH-1:0]   in_vld,
  input logic             rd_en,
  input logic             rd_vld,
  input logic [BUS_W-1:0] rd_data,
  input logic             stat_rd,
  input logic [NCH-1:0]   rdy_flags,
  input logic [NCH-1:0]   ovr_flags
);
  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_vld));

  // R2
  rdy_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !fifo_en && |(in_vld & chan_en & ~rdy_flags))
    |=> |(rdy_flags & $past(in_vld & chan_en)));

  // R2
  no_rogue_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rdy_flags & ~$past(rdy_flags) & ~$past(chan_en & {NCH{en}})) == '0));

  // R8
  hold_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !fifo_en && |(in_vld & chan_en & rdy_flags))
    |=> |(ovr_flags & $past(in_vld)));

  // R9
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && in_vld == '0) |=> (ovr_flags == '0));

  // R12
  rd_answer_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_vld);

  // R12
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_vld);

  // R12
  rd_justify_chk: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> ((rd_data >> DATA_W) == '0));
endmodule

bind rx_gather_seq rx_gather_seq_chk #(
  .NCH(NCH), .DATA_W(DATA_W), .BUS_W(BUS_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .fifo_en(fifo_en), .chan_en(chan_en),
  .in_vld(in_vld), .rd_en(rd_en), .rd_vld(rd_vld), .rd_data(rd_data),
  .stat_rd(stat_rd), .rdy_flags(rdy_flags), .ovr_flags(ovr_flags)
);

// File: tb/rx_gather_seq_test.sv
`timescale 1ns/1ps
module rx_gather_seq_test;
  localparam int NL = 2, NCH = 4, DW = 24, BW = 32, FD = 8, HS = 4, CW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic en = 0, tdm_mode = 0, pair_order = 0, fifo_en = 0, rd_en = 0, stat_rd = 0;
  logic [NCH-1:0] chan_en = '0, in_vld = '0;
  logic [NCH*DW-1:0] in_data = '0;
  logic [BW-1:0] rd_data;
  logic [CW-1:0] rd_chan;
  logic rd_vld;
  logic [NCH-1:0] rdy_flags, ovr_flags;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_gather_seq #(.NUM_LINKS(NL), .DATA_W(DW), .BUS_W(BW),
                  .FIFO_DEPTH(FD), .HOLD_SLOTS(HS)) uut (
    .clk(clk), .rst(rst), .en(en), .tdm_mode(tdm_mode), .pair_order(pair_order),
    .fifo_en(fifo_en), .chan_en(chan_en), .in_vld(in_vld), .in_data(in_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_chan(rd_chan), .rd_vld(rd_vld),
    .stat_rd(stat_rd), .rdy_flags(rdy_flags), .ovr_flags(ovr_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic restart(input logic t, input logic p, input logic f, input logic [NCH-1:0] m);
    @(negedge clk);
    rst = 1; en = 1; tdm_mode = t; pair_order = p; fifo_en = f; chan_en = m;
    in_vld = '0; rd_en = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic arrive(input int c, input logic [DW-1:0] d);
    in_vld = '0;
    in_vld[c] = 1'b1;
    in_data[c*DW +: DW] = d;
    @(negedge clk);
    in_vld = '0;
  endtask

  task automatic rd_chk(input string req, input int ec, input logic [BW-1:0] ed);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(req, {31'b0, rd_vld}, 32'd1);
    chk(req, {30'b0, rd_chan}, ec);
    chk(req, rd_data, ed);
  endtask

  task automatic t_reset();
    restart(0, 0, 0, 4'b1111);
    chk("R1 rdy", {28'b0, rdy_flags}, 0);
    chk("R1 ovr", {28'b0, ovr_flags}, 0);
    chk("R1 vld", {31'b0, rd_vld}, 0);
  endtask

  task automatic t_left_right();
    restart(0, 0, 0, 4'b1111);
    for (int c = 0; c < NCH; c++) arrive(c, 24'hA000 + 24'(c));
    chk("R2 rdy set", {28'b0, rdy_flags}, 32'hF);
    rd_chk("R3 order", 0, 32'hA000);
    rd_chk("R3 order", 2, 32'hA002);
    rd_chk("R3 order", 1, 32'hA001);
    rd_chk("R3 order", 3, 32'hA003);
    chk("R3 rdy cleared", {28'b0, rdy_flags}, 0);
  endtask

  task automatic t_pairs();
    restart(0, 1, 0, 4'b1111);
    for (int c = 0; c < NCH; c++) arrive(c, 24'hB000 + 24'(c));
    for (int c = 0; c < NCH; c++) rd_chk("R4 order", c, 32'hB000 + c);
  endtask

  task automatic t_tdm();
    restart(1, 0, 0, 4'b1111);
    for (int c = 0; c < NCH; c++) arrive(c, 24'hC000 + 24'(c));
    for (int c = 0; c < NCH; c++) rd_chk("R5 order", c, 32'hC000 + c);
  endtask

  task automatic t_skip();
    restart(0, 0, 0, 4'b1011);
    for (int c = 0; c < NCH; c++) arrive(c, 24'hD000 + 24'(c));
    chk("R2 disabled ignored", {28'b0, rdy_flags}, 32'hB);
    rd_chk("R6 skip", 0, 32'hD000);
    rd_chk("R6 skip", 1, 32'hD001);
    rd_chk("R6 skip", 3, 32'hD003);
    rd_chk("R6 wrap", 0, 32'hD000);
    en = 0;
    arrive(0, 24'h123);
    chk("R2 en low ignored", {28'b0, rdy_flags}, 0);
  endtask

  task automatic t_restart_ptr();
    restart(0, 1, 0, 4'b1111);
    for (int c = 0; c < NCH; c++) arrive(c, 24'hE000 + 24'(c));
    rd_chk("R7 pre", 0, 32'hE000);
    rd_chk("R7 pre", 1, 32'hE001);
    chan_en = 4'b0111;
    @(negedge clk);
    chan_en = 4'b1111;
    @(negedge clk);
    rd_chk("R7 mask change", 0, 32'hE000);
    en = 0;
    @(negedge clk);
    en = 1;
    @(negedge clk);
    rd_chk("R7 en rise", 0, 32'hE000);
  endtask

  task automatic t_overrun();
    restart(0, 1, 0, 4'b0010);
    arrive(1, 24'h000111);
    arrive(1, 24'h000222);
    chk("R8 ovr", {28'b0, ovr_flags}, 32'h2);
    chk("R8 rdy", {28'b0, rdy_flags}, 32'h2);
    rd_chk("R8 kept", 1, 32'h111);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    chk("R9 cleared", {28'b0, ovr_flags}, 0);
    arrive(1, 24'h333);
    arrive(1, 24'h444);
    in_vld[1] = 1; in_data[DW +: DW] = 24'h555; stat_rd = 1;
    @(negedge clk);
    in_vld = '0; stat_rd = 0;
    chk("R9 set wins", {28'b0, ovr_flags}, 32'h2);
  endtask

  task automatic t_justify();
    restart(0, 0, 0, 4'b0001);
    arrive(0, 24'hFFFFFF);
    rd_chk("R12 justify", 0, 32'h00FFFFFF);
    @(negedge clk);
    chk("R12 vld drop", {31'b0, rd_vld}, 0);
  endtask

  task automatic t_queue();
    restart(0, 0, 1, 4'b1111);
    for (int i = 0; i < FD + HS; i++) arrive(i % NCH, 24'h100 + 24'(i));
    chk("R10 no ovr yet", {28'b0, ovr_flags}, 0);
    chk("R10 rdy", {28'b0, rdy_flags}, 32'hF);
    arrive(0, 24'hBAD);
    chk("R10 ovr", {28'b0, ovr_flags}, 32'h1);
    for (int i = 0; i < FD + HS; i++) begin
      rd_chk("R10 order", i % NCH, 32'h100 + i);
      repeat (2) @(negedge clk);
    end
    chk("R11 rdy cleared", {28'b0, rdy_flags}, 0);
    rd_chk("R11 empty", 0, 32'h0);
  endtask

  initial begin
    t_reset();
    t_left_right();
    t_pairs();
    t_tdm();
    t_skip();
    t_restart_ptr();
    t_overrun();
    t_justify();
    t_queue();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule